// File: doc/BRIEF.md
# Serial Audio Sample Transmitter

This block puts a stereo pair of 24-bit two's-complement samples onto one serial data line, most significant bit first. It follows a bit clock and a word-select clock that are fed in as plain inputs. Both clocks are sampled in the system clock domain, so the same block serves whether the clocks come from a local divider or from an external clock master. Two framings are supported. In left-justified framing the MSB follows the word-select edge at once. In I2S framing it follows one bit period later. The framing is chosen once, from a strap level read in the first clock cycle after reset, and stays fixed until the next reset. Frames of 64 bit clocks and frames of 48 bit clocks are both handled.

Upstream logic offers one sample pair per frame on a valid/ready handshake into a single holding slot. At each frame start the held pair becomes the pair being sent. If nothing is held at that point, the previous pair is sent again and an underrun indication is raised. A one-cycle pulse marks every frame start.

The control is a three-state machine. STRAP waits for the single cycle after reset in which the format level is captured; its only transition, "capture", leads to SYNC. SYNC keeps the data line low and ignores bit-clock edges until the word-select clock enters the left-channel phase; that transition, "lock", leads to RUN. RUN shifts one bit on every bit-clock falling edge and has no exit other than reset.

Top module: `aud_serial_tx`

## Requirements
- R1: In the first system-clock cycle after reset is released, the block captures the format strap. A 1 selects I2S framing and a 0 selects left-justified framing. Later changes of the strap have no effect until the next reset.
- R2: In left-justified framing, the first bit-clock falling edge after a word-select change sends sample bit 23. The following falling edges send bits 22 down to 0 in turn.
- R3: In I2S framing, the first falling edge after a word-select change is a delay slot. Bit 23 follows on the second falling edge, and the lower bits follow on the edges after it.
- R4: The left sample is sent while word-select is 1 in left-justified framing and while it is 0 in I2S framing. The right sample is sent in the other phase.
- R5: Every bit slot of a half-frame after the slot that carries bit 0 is driven as 0.
- R6: With 24 bit clocks per half-frame (48 per frame), left-justified framing sends all 24 bits. In I2S framing, bit 0 of one channel is sent in the delay slot at the start of the next half-frame.
- R7: smp_ready_o is 1 exactly when the single holding slot is empty. A pair offered with smp_valid_i while ready is 1 is stored on that clock edge. An offer made while ready is 0 is ignored.
- R8: At each frame start (a word-select change into the left phase), a held pair becomes the pair being sent, the slot empties, and frame_start_o is 1 for exactly one cycle.
- R9: When the slot is empty at a frame start, the previous pair is sent again and underrun_o is set. underrun_o changes only at frame starts. A pair offered in the same cycle as an empty-slot frame start counts as an underrun and is kept for the next frame.
- R10: During and after reset, sdata_o, frame_start_o and underrun_o are 0 and smp_ready_o is 1. The data line stays 0 until the first frame start.
- R11: sdata_o changes only in the system-clock cycle that follows a sampled bit-clock falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_strap_i | input | 1 | Format strap, captured once after reset (1 = I2S, 0 = left-justified) |
| sclk_i | input | 1 | Bit clock |
| lrck_i | input | 1 | Word-select clock |
| smp_valid_i | input | 1 | A sample pair is offered |
| smp_left_i | input | 24 | Left sample, two's complement |
| smp_right_i | input | 24 | Right sample, two's complement |
| smp_ready_o | output | 1 | Holding slot empty; an offer is taken |
| sdata_o | output | 1 | Serial data line |
| frame_start_o | output | 1 | One-cycle pulse at each frame start |
| underrun_o | output | 1 | The current frame repeats the previous pair |

## Verification
Loading a new sample pair and taking over the held pair at a frame start can fall in the same cycle. The bench provokes this by offering a pair exactly in the system-clock cycle in which the falling bit-clock edge of a left-phase boundary is sampled, with the holding slot empty. It expects underrun_o to rise and smp_ready_o to fall together. The whole following frame must still repeat the old pair, and the frame after that must carry the late pair with underrun_o cleared. A behavioural model of slots and words in the bench predicts every output on every clock. The same model judges the I2S 48-clock case, where the last bit of one channel and the loading of the next word share one edge.

// File: rtl/aud_serial_tx_pkg.sv
package aud_serial_tx_pkg;

    // Default sample width in bits
    parameter int SAMPLE_W = 24;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_STRAP = 2'd0,   // capture the format strap
        ST_SYNC  = 2'd1,   // wait for the first left-phase boundary
        ST_RUN   = 2'd2    // shift one bit per bit-clock falling edge
    } tx_state_e;

endpackage

// File: rtl/aud_clk_edges.sv
module aud_clk_edges #(
    parameter int IN_STAGES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic lrck_i,
    output logic lrck_o,
    output logic sclk_fall_o,
    output logic half_start_o
);

    logic sclk_s;
    logic lrck_s;

    generate
        if (IN_STAGES == 0) begin : g_direct
            assign sclk_s = sclk_i;
            assign lrck_s = lrck_i;
        end else begin : g_sync
            logic [IN_STAGES-1:0] sc_q;
            logic [IN_STAGES-1:0] lr_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sc_q <= '0;
                    lr_q <= '0;
                end else begin
                    sc_q[0] <= sclk_i;
                    lr_q[0] <= lrck_i;
                    for (int i = 1; i < IN_STAGES; i++) begin
                        sc_q[i] <= sc_q[i-1];
                        lr_q[i] <= lr_q[i-1];
                    end
                end
            end
            assign sclk_s = sc_q[IN_STAGES-1];
            assign lrck_s = lr_q[IN_STAGES-1];
        end
    endgenerate

    logic sclk_prev_q;
    logic lr_at_fall_q;

    assign sclk_fall_o  = sclk_prev_q & ~sclk_s;
    assign half_start_o = sclk_fall_o & (lrck_s != lr_at_fall_q);
    assign lrck_o       = lrck_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q  <= 1'b0;
            lr_at_fall_q <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_s;
            if (sclk_fall_o) begin
                lr_at_fall_q <= lrck_s;
            end
        end
    end

    // R11: a falling edge cannot be seen in two consecutive cycles
    p_fall_spacing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall_o |=> !sclk_fall_o);

endmodule

// File: rtl/aud_pair_hold.sv
module aud_pair_hold #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid_i,
    input  logic [W-1:0] in_left_i,
    input  logic [W-1:0] in_right_i,
    output logic         in_ready_o,
    input  logic         take_i,
    output logic [W-1:0] cur_left_o,
    output logic [W-1:0] cur_right_o,
    output logic         underrun_o
);

    logic [W-1:0] hold_l_q, hold_r_q;
    logic [W-1:0] act_l_q,  act_r_q;
    logic         hold_full_q;
    logic         accept;
    logic         swap;

    assign in_ready_o  = ~hold_full_q;
    assign accept      = in_valid_i & in_ready_o;
    assign swap        = take_i & hold_full_q;
    assign cur_left_o  = swap ? hold_l_q : act_l_q;
    assign cur_right_o = swap ? hold_r_q : act_r_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_l_q    <= '0;
            hold_r_q    <= '0;
            act_l_q     <= '0;
            act_r_q     <= '0;
            hold_full_q <= 1'b0;
            underrun_o  <= 1'b0;
        end else begin
            if (take_i) begin
                if (hold_full_q) begin
                    act_l_q    <= hold_l_q;
                    act_r_q    <= hold_r_q;
                    underrun_o <= 1'b0;
                end else begin
                    underrun_o <= 1'b1;
                end
            end
            if (accept) begin
                hold_l_q <= in_left_i;
                hold_r_q <= in_right_i;
            end
            hold_full_q <= (hold_full_q & ~take_i) | accept;
        end
    end

    // R7: an accepted offer fills the slot and closes it
    p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> !in_ready_o);

    // R8: a takeover of a held pair reopens the slot
    p_swap_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !in_ready_o) |=> (in_ready_o && !underrun_o));

    // R9: a takeover with an empty slot flags underrun
    p_empty_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && in_ready_o) |=> underrun_o);

endmodule

// File: rtl/aud_word_shifter.sv
module aud_word_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         load_i,
    input  logic         i2s_i,
    input  logic [W-1:0] word_i,
    output logic         bit_o
);

    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] left_q;
    logic          pending;

    assign pending = (left_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
            bit_o  <= 1'b0;
        end else if (step_i) begin
            if (load_i) begin
                if (i2s_i) begin
                    // delay slot: finish any bit still owed by the old word
                    bit_o  <= pending ? sh_q[W-1] : 1'b0;
                    sh_q   <= word_i;
                    left_q <= CW'(W);
                end else begin
                    bit_o  <= word_i[W-1];
                    sh_q   <= {word_i[W-2:0], 1'b0};
                    left_q <= CW'(W - 1);
                end
            end else if (pending) begin
                bit_o  <= sh_q[W-1];
                sh_q   <= {sh_q[W-2:0], 1'b0};
                left_q <= left_q - 1'b1;
            end else begin
                bit_o <= 1'b0;
            end
        end
    end

    // R5: the count of owed bits never exceeds the word width
    p_left_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= CW'(W));

    // R3: an I2S load leaves the full word owed
    p_i2s_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && load_i && i2s_i) |=> (left_q == CW'(W)));

    // R2: a left-justified load sends the MSB at once
    p_lj_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && load_i && !i2s_i) |=> (bit_o == $past(word_i[W-1])));

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
    import aud_serial_tx_pkg::*;
#(
    parameter int W         = SAMPLE_W,
    parameter int IN_STAGES = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fmt_strap_i,
    input  logic         sclk_i,
    input  logic         lrck_i,
    input  logic         smp_valid_i,
    input  logic [W-1:0] smp_left_i,
    input  logic [W-1:0] smp_right_i,
    output logic         smp_ready_o,
    output logic         sdata_o,
    output logic         frame_start_o,
    output logic         underrun_o
);

    tx_state_e state_q, state_d;
    logic      fmt_i2s_q;

    logic      lrck_s;
    logic      sclk_fall;
    logic      half_start;
    logic      is_left;
    logic      take;
    logic      step;
    logic [W-1:0] cur_left, cur_right, word;

    aud_clk_edges #(.IN_STAGES(IN_STAGES)) u_edges (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_i       (sclk_i),
        .lrck_i       (lrck_i),
        .lrck_o       (lrck_s),
        .sclk_fall_o  (sclk_fall),
        .half_start_o (half_start)
    );

    assign is_left = fmt_i2s_q ? ~lrck_s : lrck_s;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STRAP;
        end else begin
            state_q <= state_d;
        end
    end

    // Format capture, only while in STRAP
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_i2s_q <= 1'b0;
        end else if (state_q == ST_STRAP) begin
            fmt_i2s_q <= fmt_strap_i;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STRAP: state_d = ST_SYNC;
            ST_SYNC:  if (half_start && is_left) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_STRAP;
        endcase
    end

    // State outputs
    always_comb begin
        take = 1'b0;
        step = 1'b0;
        unique case (state_q)
            ST_STRAP: begin
                take = 1'b0;
                step = 1'b0;
            end
            ST_SYNC: begin
                take = half_start & is_left;
                step = half_start & is_left;
            end
            ST_RUN: begin
                take = half_start & is_left;
                step = sclk_fall;
            end
            default: begin
                take = 1'b0;
                step = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_start_o <= 1'b0;
        end else begin
            frame_start_o <= take;
        end
    end

    aud_pair_hold #(.W(W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (smp_valid_i),
        .in_left_i   (smp_left_i),
        .in_right_i  (smp_right_i),
        .in_ready_o  (smp_ready_o),
        .take_i      (take),
        .cur_left_o  (cur_left),
        .cur_right_o (cur_right),
        .underrun_o  (underrun_o)
    );

    assign word = is_left ? cur_left : cur_right;

    aud_word_shifter #(.W(W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .load_i (half_start),
        .i2s_i  (fmt_i2s_q),
        .word_i (word),
        .bit_o  (sdata_o)
    );

    // R1: once out of STRAP the format never changes
    p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_STRAP) |=> $stable(fmt_i2s_q));

    // R11: data line holds unless a falling edge was just sampled
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(sdata_o));

    // R8: frame start is a single-cycle pulse
    p_fs_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> !frame_start_o);

    // R9: underrun moves only together with a frame start
    p_ur_at_fs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_o |-> $stable(underrun_o));

    // R10: before lock the data line stays low
    p_sync_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> !sdata_o);

endmodule

// File: tb/aud_serial_tx_tb_top.sv
module aud_serial_tx_tb_top;

    localparam int W = 24;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    // DUT inputs
    logic         rst_n = 1'b0;
    logic         fmt_strap = 1'b0;
    logic         sclk = 1'b1;
    logic         lrck = 1'b0;
    logic         smp_valid = 1'b0;
    logic [W-1:0] smp_l = '0;
    logic [W-1:0] smp_r = '0;
    // DUT outputs
    logic smp_ready, sdata, frame_start, underrun;

    aud_serial_tx dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fmt_strap_i   (fmt_strap),
        .sclk_i        (sclk),
        .lrck_i        (lrck),
        .smp_valid_i   (smp_valid),
        .smp_left_i    (smp_l),
        .smp_right_i   (smp_r),
        .smp_ready_o   (smp_ready),
        .sdata_o       (sdata),
        .frame_start_o (frame_start),
        .underrun_o    (underrun)
    );

    // Next inputs, applied by tick()
    logic         nx_rst = 1'b0, nx_strap = 1'b0, nx_sclk = 1'b1, nx_lrck = 1'b0, nx_valid = 1'b0;
    logic [W-1:0] nx_l = '0, nx_r = '0;

    // Reference model state
    logic         m_prev_sclk = 0, m_lr_fall = 0, m_cap = 0, m_run = 0, m_fmt = 0;
    logic         m_hfull = 0;
    logic [W-1:0] m_hl = '0, m_hr = '0, m_al = '0, m_ar = '0;
    logic [W-1:0] m_cur = '0, m_prevw = '0;
    int           m_slot = 0, m_prev_len = 64;
    logic         exp_sd = 0, exp_fs = 0, exp_ur = 0, exp_rdy = 1, m_was_fall = 0;

    int    checks = 0, fails = 0, data_k = 0;
    string cur_req = "R10";
    logic  tb_fmt = 1'b0;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic was_cap, fall, bnd, left, accept;
        if (!rst_n) begin
            m_prev_sclk = 0; m_lr_fall = 0; m_cap = 0; m_run = 0; m_hfull = 0;
            m_hl = '0; m_hr = '0; m_al = '0; m_ar = '0; m_cur = '0; m_prevw = '0;
            m_slot = 0; m_prev_len = 64;
            exp_sd = 0; exp_fs = 0; exp_ur = 0; exp_rdy = 1; m_was_fall = 0;
            return;
        end
        was_cap = m_cap;
        if (!m_cap) begin
            m_fmt = fmt_strap;
            m_cap = 1;
        end
        accept = smp_valid && exp_rdy;
        exp_fs = 0;
        fall = m_prev_sclk && !sclk;
        m_was_fall = fall;
        if (fall) begin
            bnd = (lrck != m_lr_fall);
            m_lr_fall = lrck;
            left = m_fmt ? !lrck : lrck;
            if (bnd && was_cap && left && !m_run) begin
                m_run = 1;
                m_slot = 31;     // previous half not tracked: nothing owed
            end
            if (m_run) begin
                if (bnd) begin
                    if (left) begin
                        exp_fs = 1;
                        if (m_hfull) begin
                            m_al = m_hl; m_ar = m_hr; m_hfull = 0; exp_ur = 0;
                        end else begin
                            exp_ur = 1;
                        end
                    end
                    m_prev_len = m_slot + 1;
                    m_prevw = m_cur;
                    m_cur = left ? m_al : m_ar;
                    m_slot = 0;
                end else begin
                    m_slot++;
                end
                if (!m_fmt) begin
                    exp_sd = (m_slot < W) ? m_cur[W-1-m_slot] : 1'b0;
                end else if (m_slot == 0) begin
                    exp_sd = (m_prev_len == W) ? m_prevw[0] : 1'b0;
                end else begin
                    exp_sd = (m_slot <= W) ? m_cur[W-m_slot] : 1'b0;
                end
            end
        end
        if (accept) begin
            m_hl = smp_l; m_hr = smp_r; m_hfull = 1;
        end
        exp_rdy = !m_hfull;
        m_prev_sclk = sclk;
    endtask

    task automatic tick();
        @(negedge clk);
        chk(m_was_fall ? cur_req : "R11", "sdata", sdata, exp_sd);
        chk("R8", "frame_start", frame_start, exp_fs);
        chk("R9", "underrun", underrun, exp_ur);
        chk("R7", "ready", smp_ready, exp_rdy);
        rst_n = nx_rst; fmt_strap = nx_strap; sclk = nx_sclk; lrck = nx_lrck;
        smp_valid = nx_valid; smp_l = nx_l; smp_r = nx_r;
        model_step();
    endtask

    task automatic half(input logic lr, input int slots, input int feed_slot);
        for (int s = 0; s < slots; s++) begin
            nx_sclk = 1'b0;
            nx_lrck = lr;
            nx_valid = (s == feed_slot);
            if (s == feed_slot) begin
                data_k++;
                nx_l = 24'hA5C000 ^ W'(data_k * 24'h013579);
                nx_r = 24'h3C0F00 ^ W'(data_k * 24'h0A0B0D) ^ 24'h800001;
            end
            tick();
            nx_valid = 1'b0;
            tick();
            nx_sclk = 1'b1;
            tick();
            tick();
        end
    endtask

    task automatic frame(input int slots, input int feed_l, input int feed_r);
        logic lv;
        lv = tb_fmt ? 1'b0 : 1'b1;
        half(lv, slots / 2, feed_l);
        half(!lv, slots / 2, feed_r);
    endtask

    task automatic do_reset(input logic strap);
        tb_fmt = strap;
        nx_rst = 1'b0; nx_strap = strap; nx_sclk = 1'b1; nx_lrck = strap; nx_valid = 1'b0;
        cur_req = "R10";
        for (int i = 0; i < 3; i++) tick();
        nx_rst = 1'b1;
        tick();          // strap captured at the following edge
        tick();
        nx_strap = !strap;   // R1: later strap changes must be ignored
        tick();
        tick();
    endtask

    initial begin
        // Left-justified
        do_reset(1'b0);
        cur_req = "R10";
        half(1'b0, 4, 1);                // lead-in, pair offered before lock
        cur_req = "R2";
        frame(64, -1, 5);
        cur_req = "R4";
        frame(64, -1, 5);
        cur_req = "R5";
        frame(64, -1, -1);
        cur_req = "R9";
        frame(64, -1, 5);                // underrun frame, feed for next
        frame(64, -1, -1);
        cur_req = "R7";
        frame(64, 0, -1);                // offer at frame start with empty slot
        frame(64, -1, -1);
        cur_req = "R6";
        frame(48, -1, 10);
        frame(48, -1, 10);
        frame(48, -1, 10);
        // I2S
        do_reset(1'b1);
        cur_req = "R1";
        half(1'b1, 4, 1);
        frame(64, -1, 5);
        cur_req = "R3";
        frame(64, -1, 5);
        frame(64, -1, 5);
        cur_req = "R6";
        frame(48, -1, 7);
        frame(48, -1, 7);
        frame(48, -1, -1);
        cur_req = "R9";
        frame(48, -1, 7);
        frame(48, -1, -1);
        cur_req = "R4";
        frame(64, -1, 5);
        frame(64, -1, 5);
        tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule